// File: doc/BRIEF.md
# Sized Little-Endian Load/Store Unit

This block carries out byte, halfword and word loads and stores that arrive at a virtual address. It accepts a request on a valid/ready channel, checks the size code, and asks an external translation unit for the physical address. It then reads or writes a local byte-addressed memory in which every multi-byte value sits least-significant byte first. The result goes back on a second valid/ready channel as a status, an exception code and, for loads, zero-extended data.

When the translation unit reports an exception, or the size code is not one of the three legal values, no memory access takes place. The response carries the fault, and the offending virtual address is latched into a bad-address register that holds it until the next fault. Back-pressure rules: a request is taken on the rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the unit is idle, so exactly one access is in flight. A response stays valid with all fields frozen until the edge where `rsp_ready` is high.

Top module: `sized_lsu`

## Requirements
- R1: `req_size` is the access width in bytes: 3'd1 byte, 3'd2 halfword, 3'd4 word. Any other code gives a response one cycle after acceptance with `rsp_fault`=1 and `rsp_exc`=3'd1 (address error). No translation is requested and memory is not changed.
- R2: `req_ready` is 1 only while no access is in flight. After acceptance it stays 0 until the edge at which the response is taken with `rsp_ready`=1.
- R3: From the cycle after acceptance of a legal request, `xlt_req` is 1 and `xlt_vaddr`, `xlt_write` and `xlt_size` show the request until the cycle in which `xlt_done` is sampled high. `rsp_valid` rises in the cycle after that.
- R4: When `xlt_done` comes with `xlt_exc` nonzero, no memory byte is written or read. The response has `rsp_fault`=1, `rsp_exc` equal to `xlt_exc`, and `rsp_rdata`=0.
- R5: `bad_vaddr` resets to 0. It takes the virtual address of every faulting access (R1 or R4) and is unchanged by successful accesses.
- R6: A byte store writes `req_wdata[7:0]` to physical byte `xlt_paddr` and touches no other byte.
- R7: A halfword store writes `req_wdata[7:0]` to byte `xlt_paddr` and `req_wdata[15:8]` to byte `xlt_paddr`+1, and nothing else.
- R8: A word store writes `req_wdata[8*i+7:8*i]` to byte `xlt_paddr`+i for i = 0..3.
- R9: A successful load returns bytes `xlt_paddr`+i in bit positions `8*i+7:8*i`, with the bits above the access width set to 0. `rsp_fault`=0 and `rsp_exc`=0. Stores return `rsp_rdata`=0.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_valid`, `rsp_fault`, `rsp_exc` and `rsp_rdata` hold their values.
- R11: After reset `req_ready`=1, `rsp_valid`=0, `xlt_req`=0 and `bad_vaddr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 3 | Access width in bytes (1, 2, 4 legal) |
| req_vaddr | input | VA_W | Virtual address |
| req_wdata | input | 32 | Store data, low bytes used |
| xlt_req | output | 1 | Translation request pending |
| xlt_vaddr | output | VA_W | Address to translate |
| xlt_write | output | 1 | Access is a store |
| xlt_size | output | 3 | Access width to translate |
| xlt_done | input | 1 | Translation answer valid |
| xlt_paddr | input | PA_W | Physical byte address |
| xlt_exc | input | 3 | Exception code, 0 = none |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_fault | output | 1 | Access aborted |
| rsp_exc | output | 3 | Exception code of the response |
| rsp_rdata | output | 32 | Zero-extended load data |
| bad_vaddr | output | VA_W | Last faulting virtual address |

## Verification
The hardest situation to reach is a store that is abandoned after translation has already been requested. Its data and address must leave no trace in memory, and nothing on the ports shows that directly. The bench first fills the whole small memory through word stores. It then aims stores carrying translator exceptions, and requests with every illegal size code, at addresses whose contents it knows. It reloads those addresses through legal loads to show the old bytes survived. It also varies the translator latency and stalls the response channel, so the frozen response and the fault path are exercised under back-pressure.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam logic [2:0] EXC_NONE = 3'd0;
  localparam logic [2:0] EXC_ADDR = 3'd1;

  localparam logic [2:0] SZ_BYTE = 3'd1;
  localparam logic [2:0] SZ_HALF = 3'd2;
  localparam logic [2:0] SZ_WORD = 3'd4;

  localparam int LANES = 4;

  function automatic logic size_ok(input logic [2:0] s);
    return (s == SZ_BYTE) || (s == SZ_HALF) || (s == SZ_WORD);
  endfunction
endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl #(
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [2:0]      req_size,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [31:0]     req_wdata,
  output logic            req_ready,
  output logic            xlt_req,
  input  logic            xlt_done,
  input  logic [2:0]      xlt_exc,
  input  logic [1:0]      xlt_off,
  input  logic            rsp_ready,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic [2:0]      rsp_exc,
  output logic [VA_W-1:0] bad_vaddr,
  output logic            acc_go,
  output logic            write_q,
  output logic [2:0]      size_q,
  output logic [VA_W-1:0] vaddr_q,
  output logic [31:0]     wdata_q,
  output logic [1:0]      off_q
);
  import lsu_pkg::*;

  typedef enum logic [1:0] {ST_IDLE, ST_XLATE, ST_RESP} state_e;
  state_e st_q;

  logic accept;
  assign accept    = (st_q == ST_IDLE) && req_valid;
  assign req_ready = (st_q == ST_IDLE);
  assign xlt_req   = (st_q == ST_XLATE);
  assign rsp_valid = (st_q == ST_RESP);
  assign acc_go    = (st_q == ST_XLATE) && xlt_done && (xlt_exc == EXC_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      write_q   <= 1'b0;
      size_q    <= 3'd0;
      vaddr_q   <= '0;
      wdata_q   <= '0;
      off_q     <= 2'd0;
      rsp_fault <= 1'b0;
      rsp_exc   <= EXC_NONE;
      bad_vaddr <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            write_q <= req_write;
            size_q  <= req_size;
            vaddr_q <= req_vaddr;
            wdata_q <= req_wdata;
            if (size_ok(req_size)) begin
              st_q <= ST_XLATE;
            end else begin
              st_q      <= ST_RESP;
              rsp_fault <= 1'b1;
              rsp_exc   <= EXC_ADDR;
              bad_vaddr <= req_vaddr;
            end
          end
        end
        ST_XLATE: begin
          if (xlt_done) begin
            st_q  <= ST_RESP;
            off_q <= xlt_off;
            if (xlt_exc != EXC_NONE) begin
              rsp_fault <= 1'b1;
              rsp_exc   <= xlt_exc;
              bad_vaddr <= vaddr_q;
            end else begin
              rsp_fault <= 1'b0;
              rsp_exc   <= EXC_NONE;
            end
          end
        end
        ST_RESP: begin
          if (rsp_ready) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsu_wr_steer.sv
module lsu_wr_steer (
  input  logic            strobe,
  input  logic [2:0]      size,
  input  logic [1:0]      off,
  input  logic [31:0]     wdata,
  output logic [3:0]      lane_we,
  output logic [3:0][7:0] lane_wd
);
  always_comb begin
    lane_we = 4'b0;
    lane_wd = '0;
    for (int i = 0; i < 4; i++) begin
      if (strobe && (3'(i) < size)) begin
        lane_we[off + 2'(i)] = 1'b1;
        lane_wd[off + 2'(i)] = wdata[8*i +: 8];
      end
    end
  end
endmodule

// File: rtl/lsu_byte_mem.sv
module lsu_byte_mem #(
  parameter int MEM_BYTES = 4096
) (
  input  logic                  clk,
  input  logic [$clog2(MEM_BYTES/4)-1:0] row,
  input  logic [3:0]            we,
  input  logic [3:0][7:0]       wd,
  input  logic                  re,
  output logic [3:0][7:0]       rd
);
  localparam int ROWS = MEM_BYTES / 4;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] arr [ROWS];
    always_ff @(posedge clk) begin
      if (we[g]) arr[row] <= wd[g];
      if (re)    rd[g]    <= arr[row];
    end
  end
endmodule

// File: rtl/lsu_rd_merge.sv
module lsu_rd_merge (
  input  logic            en,
  input  logic [2:0]      size,
  input  logic [1:0]      off,
  input  logic [3:0][7:0] lane_rd,
  output logic [31:0]     rdata
);
  always_comb begin
    rdata = 32'd0;
    for (int i = 0; i < 4; i++) begin
      if (en && (3'(i) < size)) rdata[8*i +: 8] = lane_rd[off + 2'(i)];
    end
  end
endmodule

// File: rtl/sized_lsu.sv
module sized_lsu #(
  parameter int VA_W      = 32,
  parameter int MEM_BYTES = 4096,
  localparam int PA_W     = $clog2(MEM_BYTES),
  localparam int ROW_W    = PA_W - 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [2:0]      req_size,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [31:0]     req_wdata,
  output logic            xlt_req,
  output logic [VA_W-1:0] xlt_vaddr,
  output logic            xlt_write,
  output logic [2:0]      xlt_size,
  input  logic            xlt_done,
  input  logic [PA_W-1:0] xlt_paddr,
  input  logic [2:0]      xlt_exc,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_fault,
  output logic [2:0]      rsp_exc,
  output logic [31:0]     rsp_rdata,
  output logic [VA_W-1:0] bad_vaddr
);
  logic            acc_go, write_q;
  logic [2:0]      size_q;
  logic [31:0]     wdata_q;
  logic [1:0]      off_q;
  logic [3:0]      lane_we;
  logic [3:0][7:0] lane_wd, lane_rd;

  lsu_ctrl #(.VA_W(VA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_vaddr(req_vaddr), .req_wdata(req_wdata), .req_ready(req_ready),
    .xlt_req(xlt_req), .xlt_done(xlt_done), .xlt_exc(xlt_exc),
    .xlt_off(xlt_paddr[1:0]), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_exc(rsp_exc),
    .bad_vaddr(bad_vaddr), .acc_go(acc_go), .write_q(write_q),
    .size_q(size_q), .vaddr_q(xlt_vaddr), .wdata_q(wdata_q), .off_q(off_q)
  );

  assign xlt_write = write_q;
  assign xlt_size  = size_q;

  lsu_wr_steer steer_i (
    .strobe(acc_go && write_q), .size(size_q), .off(xlt_paddr[1:0]),
    .wdata(wdata_q), .lane_we(lane_we), .lane_wd(lane_wd)
  );

  lsu_byte_mem #(.MEM_BYTES(MEM_BYTES)) mem_i (
    .clk(clk), .row(xlt_paddr[PA_W-1:2]), .we(lane_we), .wd(lane_wd),
    .re(acc_go && !write_q), .rd(lane_rd)
  );

  lsu_rd_merge merge_i (
    .en(rsp_valid && !rsp_fault && !write_q), .size(size_q), .off(off_q),
    .lane_rd(lane_rd), .rdata(rsp_rdata)
  );

  logic [ROW_W-1:0] unused_row_chk;
  assign unused_row_chk = xlt_paddr[PA_W-1:2];
endmodule

// File: rtl/sized_lsu_checker.sv
module sized_lsu_checker #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [2:0]      req_size,
  input logic            xlt_req,
  input logic            xlt_done,
  input logic [2:0]      xlt_exc,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            rsp_fault,
  input logic [2:0]      rsp_exc,
  input logic [31:0]     rsp_rdata,
  input logic [VA_W-1:0] bad_vaddr,
  input logic [3:0]      lane_we
);
  logic [2:0] sz_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sz_seen <= 3'd0;
    else if (req_valid && req_ready) sz_seen <= req_size;
  end

  logic illegal_acc;
  assign illegal_acc = req_valid && req_ready && !lsu_pkg::size_ok(req_size);

  AST_ILLEGAL_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_acc |=> rsp_valid && rsp_fault && (rsp_exc == 3'd1) && !xlt_req); // R1
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !xlt_req |-> (lane_we == 4'b0)); // R1
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (xlt_req || rsp_valid) |-> !req_ready); // R2
  AST_RSP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (xlt_req && xlt_done) |=> rsp_valid && !xlt_req); // R3
  AST_NO_WRITE_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (xlt_done && (xlt_exc != 3'd0)) |-> (lane_we == 4'b0)); // R4
  AST_BADADDR_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bad_vaddr) |-> rsp_valid && rsp_fault); // R5
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (sz_seen == 3'd1) |-> ($countones(lane_we) <= 1)); // R6
  AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (sz_seen == 3'd2) |-> ($countones(lane_we) <= 2)); // R7
  AST_ZERO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (sz_seen == 3'd1)) |-> (rsp_rdata[31:8] == 24'd0)); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata)
      && $stable(rsp_fault) && $stable(rsp_exc)); // R10
endmodule

bind sized_lsu sized_lsu_checker #(.VA_W(VA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_size(req_size), .xlt_req(xlt_req), .xlt_done(xlt_done),
  .xlt_exc(xlt_exc), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_fault(rsp_fault), .rsp_exc(rsp_exc), .rsp_rdata(rsp_rdata),
  .bad_vaddr(bad_vaddr), .lane_we(lane_we)
);

// File: tb/sized_lsu_tb_top.sv
module sized_lsu_tb_top;
  localparam int VA_W = 32;
  localparam int MB   = 64;
  localparam int PA_W = $clog2(MB);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, xlt_done = 0, rsp_ready = 0;
  logic [2:0] req_size = 0, xlt_exc = 0;
  logic [VA_W-1:0] req_vaddr = 0;
  logic [31:0] req_wdata = 0;
  logic [PA_W-1:0] xlt_paddr = 0;
  logic req_ready, xlt_req, xlt_write, rsp_valid, rsp_fault;
  logic [VA_W-1:0] xlt_vaddr, bad_vaddr;
  logic [2:0] xlt_size, rsp_exc;
  logic [31:0] rsp_rdata;

  always #10 clk = ~clk;

  sized_lsu #(.VA_W(VA_W), .MEM_BYTES(MB)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_vaddr(req_vaddr),
    .req_wdata(req_wdata), .xlt_req(xlt_req), .xlt_vaddr(xlt_vaddr),
    .xlt_write(xlt_write), .xlt_size(xlt_size), .xlt_done(xlt_done),
    .xlt_paddr(xlt_paddr), .xlt_exc(xlt_exc), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_exc(rsp_exc),
    .rsp_rdata(rsp_rdata), .bad_vaddr(bad_vaddr)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] shadow [MB];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int pmap(input logic [31:0] va);
    return int'((va + 32'd16) % MB);
  endfunction

  task automatic access(input bit wr, input logic [2:0] sz, input logic [31:0] va,
                        input logic [31:0] wd, input logic [2:0] exc,
                        input int lat, input bit hold,
                        output logic [31:0] rd, output logic flt,
                        output logic [2:0] rexc);
    bit legal;
    legal = (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready when idle", {31'd0, req_ready}, 1);
    req_valid = 1; req_write = wr; req_size = sz; req_vaddr = va; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 1'b0, "R2 busy after accept", {31'd0, req_ready}, 0);
    if (legal) begin
      chk(xlt_req && xlt_vaddr == va && xlt_write == wr && xlt_size == sz,
          "R3 translation request", xlt_vaddr, va);
      repeat (lat) @(negedge clk);
      chk(xlt_req && !rsp_valid, "R3 waits for translation", {31'd0, xlt_req}, 1);
      xlt_done = 1; xlt_paddr = PA_W'(pmap(va)); xlt_exc = exc;
      @(negedge clk);
      xlt_done = 0; xlt_exc = 0;
    end else begin
      chk(!xlt_req, "R1 no translation for illegal size", {31'd0, xlt_req}, 0);
    end
    chk(rsp_valid, "R3 response valid", {31'd0, rsp_valid}, 1);
    rd = rsp_rdata; flt = rsp_fault; rexc = rsp_exc;
    if (hold) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == rd && rsp_fault == flt && rsp_exc == rexc,
          "R10 response held", rsp_rdata, rd);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk(!rsp_valid && req_ready, "R2 idle after response", {31'd0, rsp_valid}, 0);
  endtask

  function automatic logic [31:0] expect_load(input logic [31:0] va, input int n);
    logic [31:0] v = 0;
    int p = pmap(va);
    for (int i = 0; i < n; i++) v[8*i +: 8] = shadow[p + i];
    return v;
  endfunction

  task automatic store_ok(input logic [2:0] sz, input logic [31:0] va,
                          input logic [31:0] wd, input string req);
    logic [31:0] rd; logic flt; logic [2:0] e;
    access(1, sz, va, wd, 0, int'(va % 3), va[3], rd, flt, e);
    chk(!flt && e == 0 && rd == 0, req, {28'd0, flt, e}, 0);
    for (int i = 0; i < int'(sz); i++) shadow[pmap(va) + i] = wd[8*i +: 8];
  endtask

  task automatic load_chk(input logic [2:0] sz, input logic [31:0] va,
                          input string req);
    logic [31:0] rd, ex; logic flt; logic [2:0] e;
    ex = expect_load(va, int'(sz));
    access(0, sz, va, 0, 0, int'(va % 4), va[2], rd, flt, e);
    chk(!flt && e == 0 && rd == ex, req, rd, ex);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; logic flt; logic [2:0] e; logic [31:0] old;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready && !rsp_valid && !xlt_req && bad_vaddr == 0, "R11 reset state",
        bad_vaddr, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !xlt_req, "R11 after release", {31'd0, req_ready}, 1);

    // R8 word stores fill memory
    for (int a = 0; a < MB; a += 4)
      store_ok(3'd4, 32'(a), 32'h1000_0000 * 32'(a / 4 + 1) + 32'(a * 3 + 7), "R8 word store");
    for (int a = 0; a < MB; a += 4) load_chk(3'd4, 32'(a), "R8 word readback");
    // R9 byte loads zero-extended
    for (int a = 0; a < MB; a++) load_chk(3'd1, 32'(a), "R9 byte load");

    // R6 byte stores ignore upper data bits
    for (int a = 0; a < MB; a++)
      store_ok(3'd1, 32'(a), {24'hDEADBE, 8'(a * 7 + 3)}, "R6 byte store");
    for (int a = 0; a < MB; a += 4) load_chk(3'd4, 32'(a), "R6 word view of bytes");

    // R7 halfword stores ignore upper data bits
    for (int a = 0; a < MB; a += 2)
      store_ok(3'd2, 32'(a), {16'hFFFF, 16'(a * 257 + 4660)}, "R7 halfword store");
    for (int a = 0; a < MB; a += 2) load_chk(3'd2, 32'(a), "R9 halfword load");
    for (int a = 0; a < MB; a += 4) load_chk(3'd4, 32'(a), "R7 word view of halves");
    for (int a = 1; a < MB; a += 4) load_chk(3'd1, 32'(a), "R7 high byte of half");

    // R1 illegal size codes
    for (int s = 0; s < 8; s++) begin
      if (s == 1 || s == 2 || s == 4) continue;
      for (int w = 0; w < 2; w++) begin
        old = expect_load(32'(s * 4), 4);
        access(w[0], 3'(s), 32'(s * 4), 32'hCAFE_F00D, 0, 0, w[0], rd, flt, e);
        chk(flt && e == 3'd1 && rd == 0, "R1 illegal size fault", {28'd0, flt, e}, 32'h9);
        chk(bad_vaddr == 32'(s * 4), "R5 bad address on illegal size", bad_vaddr, 32'(s * 4));
        load_chk(3'd4, 32'(s * 4), "R1 memory untouched");
      end
    end

    // R4 translator faults on stores and loads
    for (int x = 2; x < 5; x++) begin
      for (int a = 0; a < MB; a += 12) begin
        access(1, 3'd4, 32'(a) & ~32'd3, 32'h5555_AAAA, 3'(x), x - 2, 1, rd, flt, e);
        chk(flt && e == 3'(x) && rd == 0, "R4 store fault", {29'd0, e}, 32'(x));
        chk(bad_vaddr == (32'(a) & ~32'd3), "R5 bad address capture", bad_vaddr, 32'(a) & ~32'd3);
        access(0, 3'd1, 32'(a) | 32'h100, 0, 3'(x), 1, 0, rd, flt, e);
        chk(flt && e == 3'(x) && rd == 0, "R4 load fault", rd, 0);
        chk(bad_vaddr == (32'(a) | 32'h100), "R5 bad address on load fault", bad_vaddr, 32'(a) | 32'h100);
        load_chk(3'd4, 32'(a) & ~32'd3, "R4 memory untouched");
        chk(bad_vaddr == (32'(a) | 32'h100), "R5 held across success", bad_vaddr, 32'(a) | 32'h100);
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule